// File: doc/BRIEF.md
# FEAC codeword transmitter

This block produces the bit stream for a far-end alarm and control slot of a DS3 C-bit parity or E3 framer. The framer pulses `slot_en` for one clock whenever it takes a slot bit, and it samples `tx_bit` in that same cycle. Between strobes the block holds its state, so slot spacing does not matter.

The host loads one or two 6-bit payloads, selects a mode and pulses `start`. The block then sends 16-bit codewords built around each payload. It can send one codeword ten times. It can send one codeword until the host stops it. It can also send a first codeword ten times followed by a second codeword ten times, which is how a loopback command is followed by the line it applies to. When no codeword is in progress the slot carries ones and `idle` is high.

The payloads and the mode are captured when a start is accepted. After that, host writes have no effect until the transmission is over.

Top module: `feac_tx`

## Requirements
- R1: Each codeword occupies 16 consecutive slot bits. In slot order it carries eight ones, then a zero, then payload bits 0 through 5 (bit 0 first), then a zero.
- R2: Out of reset, and whenever no transmission is in progress, `tx_bit` is 1 on every slot and `idle` is 1.
- R3: The block moves to its next slot bit only in a cycle with `slot_en` high. In clocks without a strobe, `tx_bit` holds its value.
- R4: With mode 2'b00 (or the spare code 2'b11), a start sends the `code_a` codeword exactly ten times and then returns to idle.
- R5: With mode 2'b01, the `code_a` codeword repeats until a `stop` pulse. The stop takes effect at the end of the codeword in progress, and never before ten codewords have been sent. A stop given during the first ten codewords ends the run after the tenth.
- R6: With mode 2'b10, the `code_a` codeword is sent ten times, then the `code_b` codeword ten times, then the block returns to idle.
- R7: A start that is accepted while idle drops `idle` in the next clock. A start given while a transmission is in progress is ignored.
- R8: The payloads are captured when a start is accepted. Changes on `code_a` and `code_b` during a transmission do not alter the codewords being sent.
- R9: A `stop` pulse in modes other than 2'b01 has no effect, and the full codeword count is still sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_en | input | 1 | One-clock strobe: the framer consumes `tx_bit` in this cycle |
| start | input | 1 | Begin a transmission; accepted only while idle |
| stop | input | 1 | End a continuous transmission at the next allowed codeword boundary |
| mode | input | 2 | 00 ten times, 01 continuous, 10 two codewords ten times each, 11 same as 00 |
| code_a | input | 6 | Payload of the first (or only) codeword |
| code_b | input | 6 | Payload of the second codeword in mode 10 |
| tx_bit | output | 1 | Slot bit to be taken at the next strobe |
| idle | output | 1 | High when no transmission is in progress |

## Verification
The bench builds the block with its default repeat minimum of ten. This means the full ten-word count, the switch from the first to the second codeword after ten words, and the saturation of the repeat counter past ten in continuous mode are all exercised at their real lengths. Strobes are spaced three clocks apart, so the hold behaviour between strobes is visible. Stop pulses are placed both inside the first ten words and inside the twelfth word, which exercises both the ten-word floor and the wait for the codeword boundary.

// File: rtl/feac_tx_pkg.sv
package feac_tx_pkg;
  localparam int PAY_W  = 6;
  localparam int FLAG_W = 8;
  localparam int WORD_W = FLAG_W + PAY_W + 2;
  localparam int IDX_W  = $clog2(WORD_W);

  typedef enum logic [1:0] {
    M_ONCE  = 2'b00,
    M_CONT  = 2'b01,
    M_CHAIN = 2'b10,
    M_SPARE = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'b00,
    S_RUN_A = 2'b01,
    S_RUN_B = 2'b10
  } st_e;

  // Slot-order word: index 0 leaves first.
  function automatic logic [WORD_W-1:0] feac_word(input logic [PAY_W-1:0] p);
    feac_word = {1'b0, p, 1'b0, {FLAG_W{1'b1}}};
  endfunction
endpackage

// File: rtl/feac_tx_bitctr.sv
module feac_tx_bitctr
  import feac_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             word_end
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

  assign word_end = adv && (idx == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        idx <= '0;
    else if (clr)      idx <= '0;
    else if (word_end) idx <= '0;
    else if (adv)      idx <= idx + 1'b1;
  end

  // R3: position frozen between strobes
  a_r3_hold_idx: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && !clr) |=> $stable(idx));
endmodule

// File: rtl/feac_tx_ctrl.sv
module feac_tx_ctrl
  import feac_tx_pkg::*;
#(
  parameter int REPEAT_MIN = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [1:0]       mode,
  input  logic [PAY_W-1:0] code_a,
  input  logic [PAY_W-1:0] code_b,
  input  logic             word_end,
  output logic             busy,
  output logic             load,
  output logic             done,
  output logic [PAY_W-1:0] cur_code
);
  localparam int CNT_W = $clog2(REPEAT_MIN + 1);
  localparam logic [CNT_W-1:0] LAST_REP = CNT_W'(REPEAT_MIN - 1);
  localparam logic [CNT_W-1:0] CAP_REP  = CNT_W'(REPEAT_MIN);

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c);
    sat_inc = (c >= CAP_REP) ? CAP_REP : c + 1'b1;
  endfunction

  st_e              st, st_n;
  mode_e            mode_q;
  logic [CNT_W-1:0] rep_cnt, cnt_n;
  logic [PAY_W-1:0] code_a_q, code_b_q;
  logic             stop_req;
  logic             last_rep, reached, stop_any;

  assign busy     = (st != S_IDLE);
  assign load     = start && !busy;
  assign last_rep = (rep_cnt == LAST_REP);
  assign reached  = (rep_cnt >= LAST_REP);
  assign stop_any = stop_req || stop;
  assign cur_code = (st == S_RUN_B) ? code_b_q : code_a_q;

  always_comb begin
    st_n  = st;
    cnt_n = rep_cnt;
    done  = 1'b0;
    if (load) begin
      st_n  = S_RUN_A;
      cnt_n = '0;
    end else if (word_end) begin
      case (st)
        S_RUN_A: begin
          case (mode_q)
            M_CONT: begin
              if (reached && stop_any) begin
                st_n = S_IDLE; cnt_n = '0; done = 1'b1;
              end else cnt_n = sat_inc(rep_cnt);
            end
            M_CHAIN: begin
              if (last_rep) begin
                st_n = S_RUN_B; cnt_n = '0;
              end else cnt_n = sat_inc(rep_cnt);
            end
            default: begin
              if (last_rep) begin
                st_n = S_IDLE; cnt_n = '0; done = 1'b1;
              end else cnt_n = sat_inc(rep_cnt);
            end
          endcase
        end
        S_RUN_B: begin
          if (last_rep) begin
            st_n = S_IDLE; cnt_n = '0; done = 1'b1;
          end else cnt_n = sat_inc(rep_cnt);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      rep_cnt  <= '0;
      mode_q   <= M_ONCE;
      code_a_q <= '0;
      code_b_q <= '0;
      stop_req <= 1'b0;
    end else begin
      st      <= st_n;
      rep_cnt <= cnt_n;
      if (load) begin
        mode_q   <= (mode_e'(mode) == M_SPARE) ? M_ONCE : mode_e'(mode);
        code_a_q <= code_a;
        code_b_q <= code_b;
      end
      if (load || done)                          stop_req <= 1'b0;
      else if (busy && stop && mode_q == M_CONT) stop_req <= 1'b1;
    end
  end

  // R4: repeat count never passes its ceiling
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rep_cnt <= CAP_REP);
  // R5: a run ends only where the bit counter closes a word
  a_r5_end_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> word_end);
  // R6: second phase exists only in chained mode
  a_r6_phase_b_chain: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RUN_B) |-> (mode_q == M_CHAIN));
  // R7: a start while busy leaves the run untouched
  a_r7_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !word_end) |=> (busy && $stable(mode_q) && $stable(rep_cnt)));
  // R8: captured payloads frozen for the whole run
  a_r8_latched: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(code_a_q) && $stable(code_b_q)));
  // R9: pending stop exists only in continuous mode
  a_r9_stop_cont: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> (mode_q == M_CONT && busy));
endmodule

// File: rtl/feac_tx.sv
module feac_tx
  import feac_tx_pkg::*;
#(
  parameter int REPEAT_MIN = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       slot_en,
  input  logic       start,
  input  logic       stop,
  input  logic [1:0] mode,
  input  logic [5:0] code_a,
  input  logic [5:0] code_b,
  output logic       tx_bit,
  output logic       idle
);
  logic              busy, load, done, adv, word_end;
  logic [IDX_W-1:0]  idx;
  logic [PAY_W-1:0]  cur_code;
  logic [WORD_W-1:0] cur_word;

  assign adv = slot_en && busy;

  feac_tx_ctrl #(.REPEAT_MIN(REPEAT_MIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .mode(mode),
    .code_a(code_a), .code_b(code_b), .word_end(word_end),
    .busy(busy), .load(load), .done(done), .cur_code(cur_code)
  );

  feac_tx_bitctr u_bits (
    .clk(clk), .rst_n(rst_n), .clr(load), .adv(adv),
    .idx(idx), .word_end(word_end)
  );

  assign cur_word = feac_word(cur_code);
  assign tx_bit   = busy ? cur_word[idx] : 1'b1;
  assign idle     = !busy;

  // R1: every run begins at the first slot bit of a word
  a_r1_word_start: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (idx == '0));
  // R2: finishing a run returns the block to idle
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (idle && tx_bit));
endmodule

// File: tb/sim_feac_tx.sv
module sim_feac_tx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic slot_en = 1'b0, start = 1'b0, stop = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [5:0] code_a = '0, code_b = '0;
  logic tx_bit, idle;
  int n_chk = 0, n_bad = 0, cyc = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  feac_tx u0 (.clk(clk), .rst_n(rst_n), .slot_en(slot_en), .start(start),
    .stop(stop), .mode(mode), .code_a(code_a), .code_b(code_b),
    .tx_bit(tx_bit), .idle(idle));

  task automatic report();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_word(input logic [5:0] c);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      if (i < 8)                 r[i] = 1'b1;
      else if (i == 8 || i == 15) r[i] = 1'b0;
      else                        r[i] = c[i-9];
    end
    return r;
  endfunction

  task automatic strobe(output logic b);
    @(negedge clk); slot_en = 1'b1; b = tx_bit;
    @(negedge clk); slot_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic begin_tx(input logic [1:0] m, input logic [5:0] a, input logic [5:0] b);
    @(negedge clk); mode = m; code_a = a; code_b = b; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(idle == 1'b0, "R7 idle after start", {15'd0, idle}, 16'd0);
  endtask

  // ev_kind: 0 none, 1 stop pulse, 2 hold check, 3 start while busy, 4 change payloads
  task automatic word_check(input logic [5:0] code, input int ev_at, input int ev_kind, input string req);
    logic [15:0] w;
    logic b, h;
    bit held;
    for (int i = 0; i < 16; i++) begin
      if (i == ev_at) begin
        case (ev_kind)
          1: begin @(negedge clk); stop = 1'b1; @(negedge clk); stop = 1'b0; end
          2: begin
            held = 1; @(negedge clk); h = tx_bit;
            for (int k = 0; k < 12; k++) begin @(negedge clk); if (tx_bit !== h) held = 0; end
            chk(held, "R3 hold between strobes", {15'd0, tx_bit}, {15'd0, h});
          end
          3: begin
            @(negedge clk); mode = 2'b01; start = 1'b1;
            @(negedge clk); start = 1'b0;
            chk(idle == 1'b0, "R7 busy start ignored idle", {15'd0, idle}, 16'd0);
          end
          4: begin code_a = ~code_a; code_b = ~code_b; end
          default: ;
        endcase
      end
      strobe(b);
      w[i] = b;
    end
    chk(w === ref_word(code), req, w, ref_word(code));
  endtask

  task automatic idle_check(input string req);
    logic [15:0] w;
    logic b;
    for (int i = 0; i < 16; i++) begin strobe(b); w[i] = b; end
    chk(w === 16'hFFFF && idle === 1'b1, req, w, 16'hFFFF);
  endtask

  task automatic t_reset();
    chk(tx_bit === 1'b1 && idle === 1'b1, "R2 reset state", {14'd0, idle, tx_bit}, 16'd3);
    idle_check("R2 idle ones");
  endtask

  task automatic t_once();
    begin_tx(2'b00, 6'h2D, 6'h00);
    for (int n = 0; n < 10; n++) begin
      if (n == 0)      word_check(6'h2D, 8, 2, "R1 once word");
      else if (n == 3) word_check(6'h2D, 5, 4, "R8 payload latched");
      else if (n == 5) word_check(6'h2D, 6, 3, "R7 busy start word");
      else             word_check(6'h2D, -1, 0, "R4 once word");
    end
    idle_check("R4 idle after ten");
  endtask

  task automatic t_spare();
    begin_tx(2'b11, 6'h01, 6'h3F);
    for (int n = 0; n < 10; n++) word_check(6'h01, -1, 0, "R4 spare mode word");
    idle_check("R4 spare mode idle");
  endtask

  task automatic t_cont_early();
    begin_tx(2'b01, 6'h13, 6'h00);
    for (int n = 0; n < 10; n++)
      word_check(6'h13, (n == 2) ? 4 : -1, 1, "R5 continuous word");
    idle_check("R5 early stop waits for ten");
  endtask

  task automatic t_cont_long();
    begin_tx(2'b01, 6'h3E, 6'h00);
    for (int n = 0; n < 12; n++)
      word_check(6'h3E, (n == 11) ? 5 : -1, 1, "R5 continuous long word");
    idle_check("R5 stop at word boundary");
  endtask

  task automatic t_chain();
    begin_tx(2'b10, 6'h01, 6'h20);
    for (int n = 0; n < 10; n++)
      word_check(6'h01, (n == 4) ? 3 : -1, 1, "R9 chain first word with stop");
    for (int n = 0; n < 10; n++) word_check(6'h20, -1, 0, "R6 chain second word");
    idle_check("R6 idle after chain");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_once();
    t_spare();
    t_cont_early();
    t_cont_long();
    t_chain();
    report();
  end
endmodule